// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits on the path between a bus master and memory. Each 32-bit word in one of two 32 MB alias windows stands for a single bit of a 1 MB backing region. An alias read becomes one word read of the backing memory. The bridge returns only the selected bit, placed in bit 0. An alias write becomes a locked read-modify-write. The bridge reads the backing word and changes the one target bit to bit 0 of the master's write data. It then writes the word back before it accepts anything else from the master.

Both sides use a request/ready handshake. A transfer completes in the cycle where request and ready are both high. On that cycle, read data is valid on the same side. The master keeps its request and payload stable until it sees ready. Any address outside the alias windows goes straight through unchanged as a single memory transfer.

The alias offset is the address minus the window base. Bits [24:5] of the offset give the backing byte offset, and bits [4:2] give the bit within that byte. Bits [1:0] are ignored. The memory word is the aligned word that holds that byte. The bit position inside the word is (byte offset mod 4) * 8 + bit.

Top module: `bb_alias_bridge`

## Requirements
- R1: An access to 0x22000000..0x23FFFFFF targets memory word 0x20000000 + ((A - 0x22000000) >> 5 with bits [1:0] cleared), at bit position ((A >> 5) & 3) * 8 + ((A >> 2) & 7).
- R2: An access to 0x42000000..0x43FFFFFF is translated in the same way, onto the backing region at 0x40000000.
- R3: An alias read issues exactly one memory read of the target word. It returns the target bit in bit 0 of the master read data, with bits [31:1] zero.
- R4: An alias write issues one memory read and then one memory write to the same word. The written word equals the word that was read, except that the target bit now equals bit 0 of the write data. Bits [31:1] of the write data have no effect.
- R5: During an alias write, the master sees ready only when the write phase completes. No other memory transfer falls between the read phase and the write phase. A new request that follows at once is served only after the write phase.
- R6: An access outside both alias windows reaches memory as one transfer, with the same address, direction and write data. Read data returns unchanged.
- R7: Alias address 0x23FFFFE0 selects word 0x200FFFFC, bit 24.
- R8: When memory holds ready low, every phase waits. The transfer completes correctly once ready rises.
- R9: After reset, with no master request, the bridge drives no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| m_req_i | input | 1 | Master request |
| m_we_i | input | 1 | Master write (1) / read (0) |
| m_addr_i | input | 32 | Master byte address |
| m_wdata_i | input | 32 | Master write data |
| m_ready_o | output | 1 | Master transfer completes this cycle |
| m_rdata_o | output | 32 | Master read data, valid with ready on reads |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) / read (0) |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ready_i | input | 1 | Memory transfer completes this cycle |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |

## Verification
Two functions can meet in the same cycle: the end of an alias write's write phase, and the arrival of the master's next request. The bench provokes this by issuing its operations back to back, with no idle cycle between them. In the second window it also holds memory ready low on every third cycle, so the phase boundaries land on stalled and unstalled cycles alike. A memory-side monitor logs every accepted transfer. Each alias write must show exactly one read and then one write to the expected word, with no foreign transfer between them. A later plain readback must show that only the one target bit changed.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BPOS_W = $clog2(DATA_W);

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_WRITE = 1'b1
  } rmw_state_e;
endpackage

// File: rtl/bb_addr_map.sv
module bb_addr_map
  import bb_pkg::*;
#(
  parameter int unsigned NREG = 2,
  parameter int unsigned REG_AW = 20,
  parameter logic [NREG-1:0][ADDR_W-1:0] BACK_BASE = {32'h4000_0000, 32'h2000_0000},
  parameter logic [ADDR_W-1:0] ALIAS_OFS = 32'h0200_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic [BPOS_W-1:0] bit_pos_o
);
  localparam int unsigned WIN_LSB = REG_AW + 5;

  logic [NREG-1:0]             match;
  logic [NREG-1:0][ADDR_W-1:0] word;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] ALIAS_BASE = BACK_BASE[g] + ALIAS_OFS;
    assign match[g] = addr_i[ADDR_W-1:WIN_LSB] == ALIAS_BASE[ADDR_W-1:WIN_LSB];
    assign word[g]  = BACK_BASE[g] |
                      {{(ADDR_W-REG_AW){1'b0}}, addr_i[WIN_LSB-1:7], 2'b00};
  end

  always_comb begin
    hit_o       = 1'b0;
    word_addr_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (match[i]) begin
        hit_o       = 1'b1;
        word_addr_o = word[i];
      end
    end
  end

  // byte lane from offset bits [6:5], bit in byte from [4:2]
  assign bit_pos_o = {addr_i[6:5], addr_i[4:2]};
endmodule

// File: rtl/bb_rmw_seq.sv
module bb_rmw_seq
  import bb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] word_addr_i,
  input  logic [BPOS_W-1:0] bit_pos_i,
  input  logic              set_val_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              mem_ready_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] hold_addr_o,
  output logic [DATA_W-1:0] merged_o
);
  rmw_state_e        state_q, state_d;
  logic [DATA_W-1:0] old_q;
  logic [BPOS_W-1:0] pos_q;
  logic              val_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_WRITE;
      ST_WRITE: if (mem_ready_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      old_q       <= '0;
      pos_q       <= '0;
      val_q       <= 1'b0;
      hold_addr_o <= '0;
    end else begin
      state_q <= state_d;
      if (start_i && state_q == ST_IDLE) begin
        old_q       <= rdata_i;
        pos_q       <= bit_pos_i;
        val_q       <= set_val_i;
        hold_addr_o <= word_addr_i;
      end
    end
  end

  always_comb begin
    merged_o        = old_q;
    merged_o[pos_q] = val_q;
  end

  assign busy_o = state_q == ST_WRITE;

  a_r8_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_ready_i) |=> busy_o);
  a_r5_write_phase_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mem_ready_i) |=> !busy_o);
endmodule

// File: rtl/bb_alias_bridge.sv
module bb_alias_bridge
  import bb_pkg::*;
#(
  parameter int unsigned NREG = 2,
  parameter int unsigned REG_AW = 20,
  parameter logic [NREG-1:0][ADDR_W-1:0] BACK_BASE = {32'h4000_0000, 32'h2000_0000},
  parameter logic [ADDR_W-1:0] ALIAS_OFS = 32'h0200_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              m_req_i,
  input  logic              m_we_i,
  input  logic [ADDR_W-1:0] m_addr_i,
  input  logic [DATA_W-1:0] m_wdata_i,
  output logic              m_ready_o,
  output logic [DATA_W-1:0] m_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic              hit;
  logic [ADDR_W-1:0] word_addr;
  logic [BPOS_W-1:0] bit_pos;
  logic              busy;
  logic              start;
  logic              alias_wr;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] merged;

  bb_addr_map #(
    .NREG(NREG), .REG_AW(REG_AW), .BACK_BASE(BACK_BASE), .ALIAS_OFS(ALIAS_OFS)
  ) u_map (
    .addr_i(m_addr_i), .hit_o(hit), .word_addr_o(word_addr), .bit_pos_o(bit_pos)
  );

  assign alias_wr = m_req_i && hit && m_we_i && !busy;
  assign start    = alias_wr && mem_ready_i;

  bb_rmw_seq u_rmw (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start),
    .word_addr_i(word_addr), .bit_pos_i(bit_pos), .set_val_i(m_wdata_i[0]),
    .rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i),
    .busy_o(busy), .hold_addr_o(hold_addr), .merged_o(merged)
  );

  always_comb begin
    mem_req_o   = m_req_i;
    mem_we_o    = m_we_i;
    mem_addr_o  = m_addr_i;
    mem_wdata_o = m_wdata_i;
    m_ready_o   = mem_ready_i;
    m_rdata_o   = mem_rdata_i;
    if (busy) begin
      mem_req_o   = 1'b1;
      mem_we_o    = 1'b1;
      mem_addr_o  = hold_addr;
      mem_wdata_o = merged;
      m_rdata_o   = '0;
    end else if (hit) begin
      mem_addr_o = word_addr;
      if (m_we_i) begin
        mem_we_o  = 1'b0;   // read phase of the locked update
        m_ready_o = 1'b0;
        m_rdata_o = '0;
      end else begin
        m_rdata_o = {{(DATA_W-1){1'b0}}, mem_rdata_i[bit_pos]};
      end
    end
  end

  a_r5_write_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (mem_req_o && mem_we_o && mem_addr_o == $past(mem_addr_o)));
  a_r5_no_ready_in_read_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alias_wr |-> !m_ready_o);
  a_r4_one_bit_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> $countones(mem_wdata_o ^ $past(mem_rdata_i)) <= 1);
  a_r3_read_bit0_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_i && m_ready_o && hit && !m_we_i && !busy) |-> m_rdata_o[DATA_W-1:1] == '0);
  a_r6_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_i && !hit && !busy) |-> (mem_addr_o == m_addr_i && mem_we_o == m_we_i));
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!m_req_i && !busy) |-> !mem_req_o);
endmodule

// File: tb/bb_alias_bridge_tb_top.sv
`timescale 1ns/1ps
module bb_alias_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_req = 1'b0, m_we = 1'b0;
  logic [31:0] m_addr = '0, m_wdata = '0;
  logic        m_ready;
  logic [31:0] m_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b1;
  logic [31:0] mem_rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bb_alias_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .m_req_i(m_req), .m_we_i(m_we), .m_addr_i(m_addr), .m_wdata_i(m_wdata),
    .m_ready_o(m_ready), .m_rdata_o(m_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata)
  );

  // memory model: 128 words, index from address bit 30 and bits [7:2]
  logic [31:0] mem [128];
  logic [31:0] expw [128];

  function automatic logic [6:0] midx(logic [31:0] a);
    return {a[30], a[7:2]};
  endfunction

  always_comb mem_rdata = mem[midx(mem_addr)];

  always @(posedge clk)
    if (mem_req && mem_ready && mem_we) mem[midx(mem_addr)] <= mem_wdata;

  // monitor of accepted memory transfers
  int          log_n = 0;
  logic        log_we [4];
  logic [31:0] log_addr [4];
  always @(posedge clk)
    if (rst_n && mem_req && mem_ready) begin
      if (log_n < 4) begin
        log_we[log_n]   <= mem_we;
        log_addr[log_n] <= mem_addr;
      end
      log_n <= log_n + 1;
    end

  bit stall_en = 0;
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    mem_ready = !(stall_en && (cyc % 3 == 0));
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic we, input logic [31:0] a, input logic [31:0] wd,
                    output logic [31:0] rd);
    @(negedge clk);
    m_req = 1'b1; m_we = we; m_addr = a; m_wdata = wd;
    log_n = 0;
    #1;
    while (!m_ready) begin
      @(negedge clk);
      #1;
    end
    rd = m_rdata;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    m_req = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog run did not finish actual=%h expected=%h", 32'h0, 32'h1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, wa, a, wd;
    logic [6:0]  ix;
    for (int i = 0; i < 128; i++) begin mem[i] = '0; expw[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    chk(mem_req == 1'b0, "R9 no memory request after reset", {31'b0, mem_req}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk(mem_req == 1'b0 && m_ready == mem_ready, "R9 idle after release",
        {31'b0, mem_req}, 32'h0);

    // preset backing words through plain writes (R6)
    for (int r = 0; r < 2; r++)
      for (int w = 0; w < 4; w++) begin
        a  = (r == 0 ? 32'h2000_0000 : 32'h4000_0000) + 32'(w * 4);
        wd = 32'h5A3C_96E1 ^ 32'(r * 32'h1111_0000 + w * 32'h0101_0101);
        op(1'b1, a, wd, rd);
        expw[midx(a)] = wd;
        chk(log_n == 1 && log_we[0] && log_addr[0] == a, "R6 plain write single transfer",
            log_addr[0], a);
        chk(mem[midx(a)] == wd, "R6 plain write data", mem[midx(a)], wd);
      end

    // sweep every bit of 16 bytes in each window
    for (int r = 0; r < 2; r++) begin
      stall_en = (r == 1);
      for (int b = 0; b < 16; b++)
        for (int k = 0; k < 8; k++) begin
          bit v;
          v  = ((b + k + r) % 2) == 1;
          a  = (r == 0 ? 32'h2200_0000 : 32'h4200_0000) + 32'(b * 32 + k * 4);
          wa = (r == 0 ? 32'h2000_0000 : 32'h4000_0000) + 32'((b / 4) * 4);
          wd = v ? 32'h0000_0001 : 32'hFFFF_FFFE;
          op(1'b1, a, wd, rd);
          chk(log_n == 2 && !log_we[0] && log_we[1],
              r == 0 ? "R5 R1 read then write" : "R5 R8 R2 read then write",
              32'(log_n), 32'd2);
          chk(log_addr[0] == wa && log_addr[1] == wa,
              r == 0 ? "R1 word address" : "R2 word address", log_addr[1], wa);
          ix = midx(wa);
          expw[ix][(b % 4) * 8 + k] = v;
          chk(mem[ix] == expw[ix], "R4 only target bit changed", mem[ix], expw[ix]);
          op(1'b0, a, 32'hFFFF_FFFF, rd);
          chk(rd == {31'b0, v}, "R3 alias read bit 0", rd, {31'b0, v});
          chk(log_n == 1 && !log_we[0] && log_addr[0] == wa, "R3 single read",
              log_addr[0], wa);
        end
    end
    stall_en = 0;

    // plain readback (R6, R4)
    for (int r = 0; r < 2; r++)
      for (int w = 0; w < 4; w++) begin
        a = (r == 0 ? 32'h2000_0000 : 32'h4000_0000) + 32'(w * 4);
        op(1'b0, a, 32'h0, rd);
        chk(rd == expw[midx(a)], "R6 R4 plain readback", rd, expw[midx(a)]);
      end

    // top corner of the first window (R7)
    op(1'b1, 32'h200F_FFFC, 32'h0100_0000, rd);
    op(1'b0, 32'h23FF_FFE0, 32'h0, rd);
    chk(log_addr[0] == 32'h200F_FFFC, "R7 corner word", log_addr[0], 32'h200F_FFFC);
    chk(rd == 32'h1, "R7 corner bit 24", rd, 32'h1);
    op(1'b0, 32'h23FF_FFE4, 32'h0, rd);
    chk(rd == 32'h0, "R7 neighbour bit 25", rd, 32'h0);

    // address outside all windows (R6)
    op(1'b1, 32'h6000_0010, 32'hC0DE_1234, rd);
    chk(log_n == 1 && log_addr[0] == 32'h6000_0010 && log_we[0], "R6 foreign write",
        log_addr[0], 32'h6000_0010);
    op(1'b0, 32'h6000_0010, 32'h0, rd);
    chk(rd == 32'hC0DE_1234, "R6 foreign read", rd, 32'hC0DE_1234);

    idle();
    @(posedge clk);
    #1;
    chk(mem_req == 1'b0, "R9 quiet after traffic", {31'b0, mem_req}, 32'h0);
    done = 1;
    summary();
    $finish;
  end
endmodule